// File: doc/BRIEF.md
# Upstream Attach and Speed Negotiation Sequencer

This block decides when a hub's upstream port announces itself on the bus and which signalling speed it settles on. It holds the full-speed pull-up off until the configuration load has finished and bus power is present. It then attaches and watches the decoded line state for a bus reset. When a reset is seen, it drives a device chirp and then listens for the host's answering chirp. From that exchange it settles in high-speed mode, with the pull-up released, or in full-speed mode, with the pull-up kept on.

All timing is counted with a one-microsecond tick input. The line is given as an already-decoded state code. The analog drivers and the chirp electrical levels sit outside this block. The drivers use `chirp_k` to force a K state, and they use `pullup_en` to switch the pull-up resistor. Losing bus power returns the block to the detached state at any time.

Top module: `upstream_attach_ctrl`

## Requirements
- R1: `pullup_en` stays 0 until a one-cycle `cfg_done` pulse has been seen since reset. That pulse is remembered until the next reset, so a later return of bus power needs no new pulse.
- R2: When `vbus_present` is 0 at a clock edge, the next cycle shows `pullup_en`=0, `chirp_k`=0 and `mode`=0. This holds from any state.
- R3: Once the configuration has been loaded and `vbus_present` is 1, the next cycle shows `pullup_en`=1 and `mode`=1.
- R4: `line_state` uses the codes 0=SE0, 1=J, 2=K, 3=SE1. While attached in full speed, a bus reset is recognised after SE0 has lasted SE0_TICKS (default 3) consecutive ticks. `chirp_k` rises in the cycle after the edge that counts the last of those ticks.
- R5: The device chirp lasts CHIRP_TICKS ticks (default 2000, which is 2 ms). With a tick on every cycle, `chirp_k` is high for CHIRP_TICKS+1 consecutive cycles.
- R6: After the chirp, the host is expected to send three K-J pairs that start with K. Each state must last at least HOST_TICKS (default 3) ticks, and all six must arrive within LISTEN_TICKS (default 100) ticks. If they do, `mode` becomes 2 and `pullup_en` becomes 0.
- R7: If the host sends no valid handshake within the listen window, the block stays at `mode`=1 with `pullup_en`=1. A host state shorter than HOST_TICKS breaks the handshake.
- R8: After a fallback to full speed, a reset that is still in progress does not start a second chirp. A new reset is recognised only after the line has left SE0.
- R9: `mode` is 0 for detached, 1 for full speed and 2 for high speed. The value 3 never appears. Reset gives `mode`=0, `pullup_en`=0 and `chirp_k`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_done | input | 1 | One-cycle strobe: configuration load finished |
| vbus_present | input | 1 | Upstream bus power level |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| line_state | input | 2 | Decoded line state: 0 SE0, 1 J, 2 K, 3 SE1 |
| pullup_en | output | 1 | Full-speed pull-up enable |
| chirp_k | output | 1 | Drive a device chirp K on the line |
| mode | output | 2 | 0 detached, 1 full speed, 2 high speed |

## Verification
The assertions check several rules on every cycle:
- the pull-up never rises before a configuration strobe;
- loss of bus power clears every output one cycle later;
- a chirp happens only while attached at full speed;
- high speed always has the pull-up released;
- high speed is held while power remains.

Some behaviours can only be shown by the bench's scenarios:
- the exact reset-detection latency and chirp length;
- the accept or reject decision for randomly timed host K-J patterns, including one directed case with a single short state;
- the refusal to re-chirp during a reset that is still in progress.

// File: rtl/usattach_pkg.sv
// Package: shared encodings for the upstream attach sequencer.
// Assumes: line decode and mode codes are fixed by the port contract.
package usattach_pkg;
    typedef enum logic [1:0] {
        LINE_SE0 = 2'd0,
        LINE_J   = 2'd1,
        LINE_K   = 2'd2,
        LINE_SE1 = 2'd3
    } line_t;

    typedef enum logic [1:0] {
        SPD_DETACHED = 2'd0,
        SPD_FULL     = 2'd1,
        SPD_HIGH     = 2'd2
    } speed_t;

    typedef enum logic [2:0] {
        ST_DETACHED  = 3'd0,
        ST_FS_IDLE   = 3'd1,
        ST_CHIRP     = 3'd2,
        ST_LISTEN    = 3'd3,
        ST_RESET_END = 3'd4,
        ST_HS        = 3'd5
    } attach_st_t;
endpackage

// File: rtl/usattach_span_timer.sv
// Module: usattach_span_timer
// Counts microsecond ticks up to LIMIT and then holds. done is high once
// LIMIT ticks have been counted since the last clear.
// Assumes: clr has priority over tick; LIMIT >= 1.
module usattach_span_timer #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic done
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt;

    // Purpose: saturating tick counter with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (tick && (cnt != LIMIT_C)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LIMIT_C);
endmodule

// File: rtl/usattach_host_chirp_det.sv
// Module: usattach_host_chirp_det
// Recognises the host chirp: PAIRS alternating K-J pairs, starting with K,
// where each state lasts at least SEG_TICKS ticks. A state is counted once
// its run reaches SEG_TICKS. A counted state may keep running after that.
// A short run, or any SE0/SE1 state, restarts the search.
// Assumes: en is low outside the listen window, which clears all progress.
module usattach_host_chirp_det
    import usattach_pkg::*;
#(
    parameter int SEG_TICKS = 3,
    parameter int PAIRS     = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic [1:0] line,
    output logic       hs_ok
);
    localparam int SEGS  = 2 * PAIRS;
    localparam int SEG_W = $clog2(SEGS + 1);
    localparam int RUN_W = $clog2(SEG_TICKS + 1);
    localparam logic [SEG_W-1:0] SEGS_C    = SEG_W'(SEGS);
    localparam logic [RUN_W-1:0] RUN_LAST  = RUN_W'(SEG_TICKS - 1);

    logic [RUN_W-1:0] run;
    logic [SEG_W-1:0] segs;
    logic             want_k;
    logic [1:0]       want_code;
    logic [1:0]       prior_code;

    // Purpose: the state expected next, and the state just counted.
    always_comb begin
        want_code  = want_k ? LINE_K : LINE_J;
        prior_code = want_k ? LINE_J : LINE_K;
    end

    // Purpose: track the run length of the expected state and count completed states.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            run    <= '0;
            segs   <= '0;
            want_k <= 1'b1;
        end else if (segs == SEGS_C) begin
            run <= '0;
        end else if (line == want_code) begin
            if (tick) begin
                if (run == RUN_LAST) begin
                    run    <= '0;
                    segs   <= segs + 1'b1;
                    want_k <= ~want_k;
                end else begin
                    run <= run + 1'b1;
                end
            end
        end else if ((segs != '0) && (line == prior_code) && (run == '0)) begin
            run <= '0;
        end else begin
            run    <= '0;
            segs   <= '0;
            want_k <= 1'b1;
        end
    end

    assign hs_ok = (segs == SEGS_C);
endmodule

// File: rtl/usattach_fsm.sv
// Module: usattach_fsm
// The attach and speed state machine. It remembers the configuration strobe,
// attaches when power is present, and steps through reset, chirp and listen.
// It settles in full or high speed.
// Assumes: the timer and detector flags come from registers in the top level.
module usattach_fsm
    import usattach_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_done,
    input  logic       vbus,
    input  logic [1:0] line,
    input  logic       reset_seen,
    input  logic       chirp_done,
    input  logic       listen_done,
    input  logic       hs_ok,
    output attach_st_t state
);
    logic       cfg_seen;
    attach_st_t nxt;

    // Purpose: remember that the configuration load has finished.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_seen <= 1'b0;
        end else if (cfg_done) begin
            cfg_seen <= 1'b1;
        end
    end

    // Purpose: next-state decision. Loss of power overrides every state.
    always_comb begin
        nxt = state;
        if (!vbus) begin
            nxt = ST_DETACHED;
        end else begin
            unique case (state)
                ST_DETACHED:  if (cfg_seen || cfg_done) nxt = ST_FS_IDLE;
                ST_FS_IDLE:   if (reset_seen) nxt = ST_CHIRP;
                ST_CHIRP:     if (chirp_done) nxt = ST_LISTEN;
                ST_LISTEN: begin
                    if (hs_ok) nxt = ST_HS;
                    else if (listen_done) nxt = ST_RESET_END;
                end
                ST_RESET_END: if (line != LINE_SE0) nxt = ST_FS_IDLE;
                ST_HS:        nxt = ST_HS;
                default:      nxt = ST_DETACHED;
            endcase
        end
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_DETACHED;
        end else begin
            state <= nxt;
        end
    end
endmodule

// File: rtl/upstream_attach_ctrl.sv
// Module: upstream_attach_ctrl (top)
// Controls the upstream pull-up, the device chirp and speed selection for a
// hub's upstream port. The outputs are decoded from the registered state.
// Assumes: us_tick is a single-cycle pulse; line_state is synchronised.
module upstream_attach_ctrl
    import usattach_pkg::*;
#(
    parameter int SE0_TICKS    = 3,
    parameter int CHIRP_TICKS  = 2000,
    parameter int HOST_TICKS   = 3,
    parameter int HOST_PAIRS   = 3,
    parameter int LISTEN_TICKS = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_done,
    input  logic       vbus_present,
    input  logic       us_tick,
    input  logic [1:0] line_state,
    output logic       pullup_en,
    output logic       chirp_k,
    output logic [1:0] mode
);
    attach_st_t state;
    logic       reset_seen, chirp_done, listen_done, hs_ok;
    logic       se0_clr;

    // Purpose: SE0 run measurement is active only in full-speed idle.
    always_comb se0_clr = (state != ST_FS_IDLE) || (line_state != LINE_SE0);

    usattach_span_timer #(.LIMIT(SE0_TICKS)) u_se0 (
        .clk(clk), .rst_n(rst_n), .clr(se0_clr), .tick(us_tick), .done(reset_seen)
    );

    usattach_span_timer #(.LIMIT(CHIRP_TICKS)) u_chirp (
        .clk(clk), .rst_n(rst_n), .clr(state != ST_CHIRP), .tick(us_tick), .done(chirp_done)
    );

    usattach_span_timer #(.LIMIT(LISTEN_TICKS)) u_listen (
        .clk(clk), .rst_n(rst_n), .clr(state != ST_LISTEN), .tick(us_tick), .done(listen_done)
    );

    usattach_host_chirp_det #(.SEG_TICKS(HOST_TICKS), .PAIRS(HOST_PAIRS)) u_det (
        .clk(clk), .rst_n(rst_n), .en(state == ST_LISTEN), .tick(us_tick),
        .line(line_state), .hs_ok(hs_ok)
    );

    usattach_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .vbus(vbus_present),
        .line(line_state), .reset_seen(reset_seen), .chirp_done(chirp_done),
        .listen_done(listen_done), .hs_ok(hs_ok), .state(state)
    );

    // Purpose: decode the port outputs from the state.
    always_comb begin
        pullup_en = 1'b0;
        chirp_k   = 1'b0;
        mode      = SPD_DETACHED;
        unique case (state)
            ST_FS_IDLE, ST_RESET_END: begin pullup_en = 1'b1; mode = SPD_FULL; end
            ST_CHIRP:  begin pullup_en = 1'b1; chirp_k = 1'b1; mode = SPD_FULL; end
            ST_LISTEN: begin pullup_en = 1'b1; mode = SPD_FULL; end
            ST_HS:     begin mode = SPD_HIGH; end
            default:   begin mode = SPD_DETACHED; end
        endcase
    end
endmodule

// File: rtl/usattach_checker.sv
// Module: usattach_checker
// Cycle-level properties of the attach sequencer, bound to the top module.
// Assumes: it sees only the top-level ports.
module usattach_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_done,
    input logic       vbus_present,
    input logic [1:0] line_state,
    input logic       pullup_en,
    input logic       chirp_k,
    input logic [1:0] mode
);
    logic cfg_flag;

    // Purpose: independent record of a configuration strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_flag <= 1'b0;
        else if (cfg_done) cfg_flag <= 1'b1;
    end

    assert_pullup_after_cfg_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pullup_en |-> cfg_flag);

    assert_power_loss_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !vbus_present |=> (!pullup_en && !chirp_k && mode == 2'd0));

    assert_chirp_attached_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chirp_k |-> (pullup_en && mode == 2'd1));

    assert_chirp_after_se0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chirp_k) |-> ($past(line_state) == 2'd0));

    assert_hs_no_pullup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> !pullup_en);

    assert_hs_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && vbus_present) |=> (mode == 2'd2));

    assert_mode_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'd3);
endmodule

bind upstream_attach_ctrl usattach_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .vbus_present(vbus_present),
    .line_state(line_state), .pullup_en(pullup_en), .chirp_k(chirp_k), .mode(mode)
);

// File: tb/sim_upstream_attach_ctrl.sv
module sim_upstream_attach_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SE0_T = 3;
    localparam int CHIRP_T = 2000;
    localparam int HOST_T = 3;
    localparam int LISTEN_T = 100;

    logic clk = 0, rst_n = 0, cfg_done = 0, vbus_present = 0, us_tick = 1;
    logic [1:0] line_state = 2'd1;
    logic pullup_en, chirp_k;
    logic [1:0] mode;
    int checks = 0, errors = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    upstream_attach_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .vbus_present(vbus_present),
        .us_tick(us_tick), .line_state(line_state), .pullup_en(pullup_en),
        .chirp_k(chirp_k), .mode(mode)
    );

    task automatic chk(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    function automatic int exp_detect_cycles();
        return SE0_T + 1;
    endfunction

    function automatic int exp_chirp_cycles();
        return CHIRP_T + 1;
    endfunction

    // Handshake accepted when all six states are long enough and fit the window.
    function automatic bit exp_hs(int lens[6]);
        int sum = 0;
        for (int s = 0; s < 6; s++) begin
            if (lens[s] < HOST_T) return 0;
            sum += lens[s];
        end
        return sum < LISTEN_T;
    endfunction

    // Drive SE0, then measure the reset-detection latency and the chirp length (R4, R5).
    task automatic reset_and_chirp();
        int n = 0, m = 1;
        @(negedge clk); line_state = 2'd0;
        do begin @(negedge clk); n++; end while (!chirp_k && n < 50);
        chk("R4 detect latency", n, exp_detect_cycles());
        do begin @(negedge clk); if (chirp_k) m++; end while (chirp_k && m < 3000);
        chk("R5 chirp length", m, exp_chirp_cycles());
    endtask

    // Send six host states (K first), then SE0.
    task automatic host_pattern(int lens[6]);
        for (int s = 0; s < 6; s++) begin
            line_state = (s % 2 == 0) ? 2'd2 : 2'd1;
            repeat (lens[s]) @(negedge clk);
        end
        line_state = 2'd0;
    endtask

    task automatic finish_negotiation(int lens[6], string tag);
        bit hs = exp_hs(lens);
        host_pattern(lens);
        repeat (LISTEN_T + 5) @(negedge clk);
        chk({tag, " mode"}, mode, hs ? 2 : 1);
        chk({tag, " pullup"}, pullup_en, hs ? 0 : 1);
        if (!hs) begin
            repeat (30) @(negedge clk);
            chk("R8 no rechirp during reset", chirp_k, 0);
        end
    endtask

    initial begin
        int lens[6];
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk("R9 reset mode", mode, 0);
        chk("R9 reset pullup", pullup_en, 0);
        chk("R9 reset chirp", chirp_k, 0);
        rst_n = 1;
        vbus_present = 1;
        repeat (10) @(negedge clk);
        chk("R1 no pullup before cfg", pullup_en, 0);
        vbus_present = 0;
        cfg_done = 1; @(negedge clk); cfg_done = 0;
        repeat (10) @(negedge clk);
        chk("R2 no pullup without vbus", pullup_en, 0);
        vbus_present = 1;
        @(negedge clk);
        chk("R3 attach pullup", pullup_en, 1);
        chk("R3 attach mode", mode, 1);

        // Directed: exact minimum-length handshake.
        lens = '{3, 3, 3, 3, 3, 3};
        reset_and_chirp();
        finish_negotiation(lens, "R6 minimum states");
        vbus_present = 0; line_state = 2'd1;
        @(negedge clk);
        chk("R2 drop from HS mode", mode, 0);
        chk("R2 drop from HS pullup", pullup_en, 0);
        vbus_present = 1;
        @(negedge clk);
        chk("R1 cfg remembered", pullup_en, 1);

        // Directed: one short J breaks the handshake.
        lens = '{3, 2, 3, 3, 3, 3};
        reset_and_chirp();
        finish_negotiation(lens, "R7 short state");
        line_state = 2'd1; repeat (2) @(negedge clk);
        chk("R8 idle in full speed", chirp_k, 0);

        // Random patterns.
        for (int it = 0; it < 6; it++) begin
            for (int s = 0; s < 6; s++)
                lens[s] = (it % 3 == 0) ? 1 + int'($urandom_range(1, 0)) : int'($urandom_range(8, 2));
            reset_and_chirp();
            finish_negotiation(lens, exp_hs(lens) ? "R6 random" : "R7 random");
            if (mode == 2) begin
                vbus_present = 0; line_state = 2'd1; @(negedge clk);
                chk("R2 drop", mode, 0);
                vbus_present = 1; @(negedge clk);
            end else begin
                line_state = 2'd1; repeat (2) @(negedge clk);
            end
        end

        // Directed: power loss during the chirp.
        @(negedge clk); line_state = 2'd0;
        while (!chirp_k) @(negedge clk);
        repeat (int'($urandom_range(500, 10))) @(negedge clk);
        vbus_present = 0;
        @(negedge clk);
        chk("R2 chirp stops", chirp_k, 0);
        chk("R2 pullup drops", pullup_en, 0);
        chk("R2 mode detached", mode, 0);
        line_state = 2'd1; vbus_present = 1;
        @(negedge clk);
        chk("R3 reattach", mode, 1);

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule